// File: doc/BRIEF.md
# Predicated Element Loop Sequencer

This block sits between instruction decode and an execution unit. When a scalar instruction names a register that has been tagged as a vector, decode pulses `start` and the sequencer expands that one instruction into a run of element operations. It walks an outer loop over the vector length and, inside each element, an inner loop over the sub-vector length. For every step it presents an element index, a sub-element index and the three operand register numbers to the execution unit. Each step uses a single request/accept handshake, and the unit reports in the accepting cycle whether the operation raised an exception or produced a zero result.

A per-element predicate decides what happens to each element group. The predicate bit can be inverted, and the predicate source can be the hard-wired zero register. A masked-out group is either skipped or turned into zero-write requests, depending on the zeroing flag. The loop position is exposed as element and sub-element offsets. These offsets freeze on an exception, so the trap handler can save them and a later `start` resumes from them. In fail-on-first mode, a zero result truncates the reported vector length to the index of the failing element.

The configuration inputs (`subvl_in`, bases, vector flags, `mask`, `mask_inv`, `pred_x0`, `zeroing`, `ffirst`) must stay stable while `busy` is high. `vl_in` and `subvl_in` must be at least 1.

Top module: `elem_loop_seq`

## Requirements
- R1: For a vector operand, the register number of step (i, s) is base + i*SUBVL + s, taken modulo 128. For a scalar operand, it is the base unchanged.
- R2: After `start`, the first step is at the element and sub-element given by `res_idx`/`res_sub`, not at zero.
- R3: When zeroing is off, an element whose predicate bit is 0 issues nothing, and the loop moves on to the next element.
- R4: When zeroing is on, an element whose predicate bit is 0 issues each of its sub-steps with `issue_zero`=1. `issue_zero` is never 1 while zeroing is off.
- R5: An accepted step with `resp_exc`=1 ends the loop with `done`=1 and `trap`=1. After this, `elem_offs`/`sub_offs` equal the index pair of the faulting step.
- R6: A loop that runs to its last step ends with `done`=1, `trap`=0, both offsets at 0 and `vl_out` equal to the starting VL.
- R7: Each element issues SUBVL sub-steps, with s running from 0 to SUBVL-1. One predicate bit, `mask[i]`, governs the whole group.
- R8: When `ffirst`=1, an accepted non-zero-write step with `resp_zero`=1 at element i ends the loop. After this, `vl_out`=i and both offsets are 0.
- R9: When `ffirst`=1 and zeroing is on, the first masked-out element (after its zero write is accepted) ends the loop with `vl_out` set to its index. When zeroing is off, masked-out elements never end the loop.
- R10: The predicate bit of element i is (`pred_x0` ? 0 : `mask[i]`) XOR `mask_inv`. With `pred_x0`=1 and `mask_inv`=1, every element is active.
- R11: A resume element offset at or above VL is clamped to VL-1. A resume sub-element offset at or above SUBVL is clamped to SUBVL-1.
- R12: Steps are issued in increasing (i, s) order, at most one per cycle. A step that is not accepted is held unchanged in the next cycle.
- R13: `done` is a single-cycle pulse in the cycle after the final step. `busy` is high from the cycle after `start` until the loop ends. Reset clears `busy`, `done`, `trap`, `vl_out` and the offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a loop (accepted when idle) |
| vl_in | input | 6 | Vector length, 1..MAX_VL |
| subvl_in | input | 3 | Sub-vector length, 1..MAX_SUB |
| res_idx | input | 5 | Element offset to resume from |
| res_sub | input | 2 | Sub-element offset to resume from |
| rd_base | input | 7 | Destination base register |
| rs1_base | input | 7 | First source base register |
| rs2_base | input | 7 | Second source base register |
| rd_vec | input | 1 | Destination is a vector |
| rs1_vec | input | 1 | First source is a vector |
| rs2_vec | input | 1 | Second source is a vector |
| mask | input | 32 | Predicate mask, bit i for element i |
| mask_inv | input | 1 | Invert predicate bits |
| pred_x0 | input | 1 | Predicate source is the zero register |
| zeroing | input | 1 | Write zero to masked-out elements |
| ffirst | input | 1 | Fail-on-first mode |
| issue_ready | input | 1 | Execution unit accepts the current step |
| resp_exc | input | 1 | Accepted step raised an exception |
| resp_zero | input | 1 | Accepted step produced a zero result |
| busy | output | 1 | Loop in progress |
| issue_valid | output | 1 | Step request |
| issue_zero | output | 1 | Request is a zero write to rd |
| issue_idx | output | 5 | Element index of the step |
| issue_sub | output | 2 | Sub-element index of the step |
| issue_rd | output | 7 | Destination register of the step |
| issue_rs1 | output | 7 | First source register of the step |
| issue_rs2 | output | 7 | Second source register of the step |
| done | output | 1 | Loop ended (one cycle) |
| trap | output | 1 | Loop ended by an exception (with done) |
| vl_out | output | 6 | Current, possibly truncated, vector length |
| elem_offs | output | 5 | Saved element offset |
| sub_offs | output | 2 | Saved sub-element offset |

## Verification
The bound checker watches several properties on every cycle:
- a held request stays unchanged while it is stalled, and steps advance in order;
- scalar operands keep their base register;
- zero writes appear only in zeroing mode;
- after a trap, the offsets capture the faulting step, and after a clean end they return to zero;
- `done` never lasts longer than one cycle.

Other behaviour needs whole scenarios driven by the scoreboard: the exact list of steps for each mask, inversion and sub-vector setting; the wrap of vector register numbers; the clamped and resumed start points; and the truncated length after fail-on-first.

// File: rtl/elseq_pkg.sv
package elseq_pkg;

    localparam int REG_W    = 7;
    localparam int NUM_OPND = 3;

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } seq_state_e;

    typedef struct packed {
        logic [REG_W-1:0] base;
        logic             vec;
    } opnd_cfg_t;

    function automatic logic [REG_W-1:0] step_reg(opnd_cfg_t cfg, logic [REG_W-1:0] lin);
        return cfg.vec ? cfg.base + lin : cfg.base;
    endfunction

endpackage

// File: rtl/elseq_pred.sv
module elseq_pred #(
    parameter int MAX_VL = 32,
    localparam int IDXW  = $clog2(MAX_VL)
) (
    input  logic [MAX_VL-1:0] mask,
    input  logic              mask_inv,
    input  logic              pred_x0,
    input  logic [IDXW-1:0]   idx,
    output logic              pbit
);
    logic raw_bit;

    always_comb begin
        raw_bit = pred_x0 ? 1'b0 : mask[idx];
        pbit    = raw_bit ^ mask_inv;
    end
endmodule

// File: rtl/elseq_opnd.sv
module elseq_opnd
    import elseq_pkg::*;
#(
    parameter int MAX_VL  = 32,
    parameter int MAX_SUB = 4,
    localparam int IDXW   = $clog2(MAX_VL),
    localparam int SUBW   = (MAX_SUB > 1) ? $clog2(MAX_SUB) : 1,
    localparam int SVW    = $clog2(MAX_SUB + 1)
) (
    input  opnd_cfg_t        cfg,
    input  logic [IDXW-1:0]  idx,
    input  logic [SUBW-1:0]  sub,
    input  logic [SVW-1:0]   subvl,
    output logic [REG_W-1:0] reg_num
);
    logic [REG_W-1:0] lin;

    always_comb begin
        lin     = REG_W'(idx) * REG_W'(subvl) + REG_W'(sub);
        reg_num = step_reg(cfg, lin);
    end
endmodule

// File: rtl/elseq_ctrl.sv
module elseq_ctrl
    import elseq_pkg::*;
#(
    parameter int MAX_VL  = 32,
    parameter int MAX_SUB = 4,
    localparam int IDXW   = $clog2(MAX_VL),
    localparam int VLW    = $clog2(MAX_VL + 1),
    localparam int SUBW   = (MAX_SUB > 1) ? $clog2(MAX_SUB) : 1,
    localparam int SVW    = $clog2(MAX_SUB + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [VLW-1:0]  vl_in,
    input  logic [SVW-1:0]  subvl_in,
    input  logic [IDXW-1:0] res_idx,
    input  logic [SUBW-1:0] res_sub,
    input  logic            pbit,
    input  logic            zeroing,
    input  logic            ffirst,
    input  logic            issue_ready,
    input  logic            resp_exc,
    input  logic            resp_zero,
    output logic            busy,
    output logic            issue_valid,
    output logic            issue_zero,
    output logic [IDXW-1:0] cur_idx,
    output logic [SUBW-1:0] cur_sub,
    output logic [SVW-1:0]  cur_subvl,
    output logic            done,
    output logic            trap,
    output logic [VLW-1:0]  vl_out
);
    seq_state_e      st_q;
    logic [IDXW-1:0] idx_q;
    logic [SUBW-1:0] sub_q;
    logic [VLW-1:0]  vl_q;
    logic [SVW-1:0]  subvl_q;
    logic            done_q;
    logic            trap_q;

    logic [IDXW-1:0] start_idx;
    logic [SUBW-1:0] start_sub;
    logic            running;
    logic            fire;
    logic            skip;
    logic            ff_stop;
    logic            last_elem;
    logic            last_sub;

    always_comb begin
        start_idx = (VLW'(res_idx) >= vl_in) ? IDXW'(vl_in - 1'b1) : res_idx;
        start_sub = (SVW'(res_sub) >= subvl_in) ? SUBW'(subvl_in - 1'b1) : res_sub;
        running   = (st_q == ST_RUN);
        issue_valid = running && (pbit || zeroing);
        issue_zero  = running && !pbit && zeroing;
        fire      = issue_valid && issue_ready;
        skip      = running && !pbit && !zeroing;
        ff_stop   = fire && !resp_exc && ffirst && (resp_zero || issue_zero);
        last_elem = (VLW'(idx_q) == vl_q - 1'b1);
        last_sub  = (SVW'(sub_q) == subvl_q - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            idx_q   <= '0;
            sub_q   <= '0;
            vl_q    <= '0;
            subvl_q <= '0;
            done_q  <= 1'b0;
            trap_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            trap_q <= 1'b0;
            if (st_q == ST_IDLE) begin
                if (start) begin
                    st_q    <= ST_RUN;
                    vl_q    <= vl_in;
                    subvl_q <= subvl_in;
                    idx_q   <= start_idx;
                    sub_q   <= start_sub;
                end
            end else if (fire && resp_exc) begin
                st_q   <= ST_IDLE;
                done_q <= 1'b1;
                trap_q <= 1'b1;
            end else if (ff_stop) begin
                st_q   <= ST_IDLE;
                done_q <= 1'b1;
                vl_q   <= VLW'(idx_q);
                idx_q  <= '0;
                sub_q  <= '0;
            end else if (skip || (fire && last_sub)) begin
                sub_q <= '0;
                if (last_elem) begin
                    st_q   <= ST_IDLE;
                    done_q <= 1'b1;
                    idx_q  <= '0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end else if (fire) begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end

    assign busy      = running;
    assign cur_idx   = idx_q;
    assign cur_sub   = sub_q;
    assign cur_subvl = subvl_q;
    assign done      = done_q;
    assign trap      = trap_q;
    assign vl_out    = vl_q;
endmodule

// File: rtl/elem_loop_seq.sv
module elem_loop_seq
    import elseq_pkg::*;
#(
    parameter int MAX_VL  = 32,
    parameter int MAX_SUB = 4,
    localparam int IDXW   = $clog2(MAX_VL),
    localparam int VLW    = $clog2(MAX_VL + 1),
    localparam int SUBW   = (MAX_SUB > 1) ? $clog2(MAX_SUB) : 1,
    localparam int SVW    = $clog2(MAX_SUB + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [VLW-1:0]    vl_in,
    input  logic [SVW-1:0]    subvl_in,
    input  logic [IDXW-1:0]   res_idx,
    input  logic [SUBW-1:0]   res_sub,
    input  logic [REG_W-1:0]  rd_base,
    input  logic [REG_W-1:0]  rs1_base,
    input  logic [REG_W-1:0]  rs2_base,
    input  logic              rd_vec,
    input  logic              rs1_vec,
    input  logic              rs2_vec,
    input  logic [MAX_VL-1:0] mask,
    input  logic              mask_inv,
    input  logic              pred_x0,
    input  logic              zeroing,
    input  logic              ffirst,
    input  logic              issue_ready,
    input  logic              resp_exc,
    input  logic              resp_zero,
    output logic              busy,
    output logic              issue_valid,
    output logic              issue_zero,
    output logic [IDXW-1:0]   issue_idx,
    output logic [SUBW-1:0]   issue_sub,
    output logic [REG_W-1:0]  issue_rd,
    output logic [REG_W-1:0]  issue_rs1,
    output logic [REG_W-1:0]  issue_rs2,
    output logic              done,
    output logic              trap,
    output logic [VLW-1:0]    vl_out,
    output logic [IDXW-1:0]   elem_offs,
    output logic [SUBW-1:0]   sub_offs
);
    logic            pbit;
    logic [IDXW-1:0] cur_idx;
    logic [SUBW-1:0] cur_sub;
    logic [SVW-1:0]  cur_subvl;
    opnd_cfg_t        cfg_arr [NUM_OPND];
    logic [REG_W-1:0] reg_arr [NUM_OPND];

    always_comb begin
        cfg_arr[0] = '{base: rd_base,  vec: rd_vec};
        cfg_arr[1] = '{base: rs1_base, vec: rs1_vec};
        cfg_arr[2] = '{base: rs2_base, vec: rs2_vec};
    end

    elseq_pred #(.MAX_VL(MAX_VL)) u_pred (
        .mask     (mask),
        .mask_inv (mask_inv),
        .pred_x0  (pred_x0),
        .idx      (cur_idx),
        .pbit     (pbit)
    );

    elseq_ctrl #(.MAX_VL(MAX_VL), .MAX_SUB(MAX_SUB)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .vl_in       (vl_in),
        .subvl_in    (subvl_in),
        .res_idx     (res_idx),
        .res_sub     (res_sub),
        .pbit        (pbit),
        .zeroing     (zeroing),
        .ffirst      (ffirst),
        .issue_ready (issue_ready),
        .resp_exc    (resp_exc),
        .resp_zero   (resp_zero),
        .busy        (busy),
        .issue_valid (issue_valid),
        .issue_zero  (issue_zero),
        .cur_idx     (cur_idx),
        .cur_sub     (cur_sub),
        .cur_subvl   (cur_subvl),
        .done        (done),
        .trap        (trap),
        .vl_out      (vl_out)
    );

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        elseq_opnd #(.MAX_VL(MAX_VL), .MAX_SUB(MAX_SUB)) u_opnd (
            .cfg     (cfg_arr[g]),
            .idx     (cur_idx),
            .sub     (cur_sub),
            .subvl   (cur_subvl),
            .reg_num (reg_arr[g])
        );
    end

    assign issue_idx = cur_idx;
    assign issue_sub = cur_sub;
    assign issue_rd  = reg_arr[0];
    assign issue_rs1 = reg_arr[1];
    assign issue_rs2 = reg_arr[2];
    assign elem_offs = cur_idx;
    assign sub_offs  = cur_sub;
endmodule

// File: rtl/elem_loop_seq_chk.sv
module elem_loop_seq_chk #(
    parameter int MAX_VL  = 32,
    parameter int MAX_SUB = 4,
    localparam int IDXW   = $clog2(MAX_VL),
    localparam int SUBW   = (MAX_SUB > 1) ? $clog2(MAX_SUB) : 1
) (
    input logic            clk,
    input logic            rst,
    input logic [6:0]      rd_base,
    input logic            rd_vec,
    input logic            zeroing,
    input logic            issue_ready,
    input logic            resp_exc,
    input logic            issue_valid,
    input logic            issue_zero,
    input logic [IDXW-1:0] issue_idx,
    input logic [SUBW-1:0] issue_sub,
    input logic [6:0]      issue_rd,
    input logic            done,
    input logic            trap,
    input logic [IDXW-1:0] elem_offs,
    input logic [SUBW-1:0] sub_offs
);
    AST_SCALAR_BASE: assert property (@(posedge clk) disable iff (rst)
        issue_valid && !rd_vec |-> issue_rd == rd_base); // R1

    AST_ZERO_WR_MODE: assert property (@(posedge clk) disable iff (rst)
        issue_valid && issue_zero |-> zeroing); // R4

    AST_TRAP_OFFS: assert property (@(posedge clk) disable iff (rst)
        issue_valid && issue_ready && resp_exc |=>
            elem_offs == $past(issue_idx) && sub_offs == $past(issue_sub)); // R5

    AST_END_OFFS_ZERO: assert property (@(posedge clk) disable iff (rst)
        done && !trap |-> elem_offs == '0 && sub_offs == '0); // R6

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        issue_valid && !issue_ready |=>
            issue_valid && $stable(issue_idx) && $stable(issue_sub) && $stable(issue_zero)); // R12

    AST_IN_ORDER: assert property (@(posedge clk) disable iff (rst)
        issue_valid && issue_ready && !resp_exc |=>
            !issue_valid || issue_idx > $past(issue_idx) ||
            (issue_idx == $past(issue_idx) && issue_sub > $past(issue_sub))); // R12

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R13
endmodule

bind elem_loop_seq elem_loop_seq_chk #(.MAX_VL(MAX_VL), .MAX_SUB(MAX_SUB)) u_chk (.*);

// File: tb/elem_loop_seq_bench.sv
module elem_loop_seq_bench;
    localparam int MAX_VL = 32;

    typedef struct {
        int idx; int sub; int rd; int rs1; int rs2; bit zero;
    } step_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [5:0]  vl_in = 6'd1;
    logic [2:0]  subvl_in = 3'd1;
    logic [4:0]  res_idx = '0;
    logic [1:0]  res_sub = '0;
    logic [6:0]  rd_base = '0, rs1_base = '0, rs2_base = '0;
    logic        rd_vec = 1'b0, rs1_vec = 1'b0, rs2_vec = 1'b0;
    logic [31:0] mask = '0;
    logic        mask_inv = 1'b0, pred_x0 = 1'b0, zeroing = 1'b0, ffirst = 1'b0;
    logic        issue_ready = 1'b0, resp_exc = 1'b0, resp_zero = 1'b0;
    logic        busy, issue_valid, issue_zero, done, trap;
    logic [4:0]  issue_idx, elem_offs;
    logic [1:0]  issue_sub, sub_offs;
    logic [6:0]  issue_rd, issue_rs1, issue_rs2;
    logic [5:0]  vl_out;

    int n_checks = 0;
    int n_fail = 0;
    int exc_i = -1, exc_s = -1, zero_i = -1;
    bit stall_en = 1'b0;
    int stall_cnt = 0;
    string cur_tag = "R1";
    step_t exp_q[$];

    always #5 clk = ~clk;

    elem_loop_seq u_elem_loop_seq (.*);

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int opreg(int base, bit vec, int i, int s, int sv);
        return vec ? ((base + i * sv + s) % 128) : base;
    endfunction

    // Responder and scoreboard monitor, acting away from the active edge.
    always @(negedge clk) begin
        stall_cnt++;
        issue_ready <= stall_en ? (stall_cnt % 3 != 0) : 1'b1;
        if (issue_valid) begin
            resp_exc  <= (int'(issue_idx) == exc_i && int'(issue_sub) == exc_s);
            resp_zero <= (int'(issue_idx) == zero_i && issue_sub == 2'd0);
        end else begin
            resp_exc  <= 1'b0;
            resp_zero <= 1'b0;
        end
    end

    always @(posedge clk) begin
        if (!rst && issue_valid && issue_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, cur_tag, "unexpected step idx", int'(issue_idx), -1);
            end else begin
                step_t e;
                e = exp_q.pop_front();
                check(int'(issue_idx) == e.idx, cur_tag, "step idx", int'(issue_idx), e.idx);
                check(int'(issue_sub) == e.sub, cur_tag, "step sub", int'(issue_sub), e.sub);
                check(int'(issue_rd) == e.rd, cur_tag, "step rd", int'(issue_rd), e.rd);
                check(int'(issue_rs1) == e.rs1, cur_tag, "step rs1", int'(issue_rs1), e.rs1);
                check(int'(issue_rs2) == e.rs2, cur_tag, "step rs2", int'(issue_rs2), e.rs2);
                check(issue_zero == e.zero, cur_tag, "zero write", int'(issue_zero), int'(e.zero));
            end
        end
    end

    // Driver: builds the expected step list and outcome, starts the loop, checks the end.
    task automatic run_case(string tag);
        int vl, sv, ri, rs, e_vl, e_oi, e_os, wait_cyc;
        bit e_trap, stop, p;
        vl = int'(vl_in); sv = int'(subvl_in);
        ri = (int'(res_idx) >= vl) ? vl - 1 : int'(res_idx);
        rs = (int'(res_sub) >= sv) ? sv - 1 : int'(res_sub);
        e_vl = vl; e_oi = 0; e_os = 0; e_trap = 0; stop = 0;
        cur_tag = tag;
        exp_q.delete();
        for (int i = ri; i < vl && !stop; i++) begin
            p = (pred_x0 ? 1'b0 : mask[i]) ^ mask_inv;
            if (!p && !zeroing) continue;
            for (int s = (i == ri) ? rs : 0; s < sv && !stop; s++) begin
                step_t e;
                e.idx = i; e.sub = s; e.zero = !p;
                e.rd  = opreg(int'(rd_base), rd_vec, i, s, sv);
                e.rs1 = opreg(int'(rs1_base), rs1_vec, i, s, sv);
                e.rs2 = opreg(int'(rs2_base), rs2_vec, i, s, sv);
                exp_q.push_back(e);
                if (i == exc_i && s == exc_s) begin
                    e_trap = 1; e_oi = i; e_os = s; stop = 1;
                end else if (ffirst && (!p || (i == zero_i && s == 0))) begin
                    e_vl = i; stop = 1;
                end
            end
        end
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(busy == 1'b1, "R13", "busy after start", int'(busy), 1);
        wait_cyc = 0;
        while (!done && wait_cyc < 1000) begin
            @(negedge clk); wait_cyc++;
        end
        check(done == 1'b1, tag, "loop ended", int'(done), 1);
        check(exp_q.size() == 0, tag, "steps left unissued", exp_q.size(), 0);
        check(trap == e_trap, tag, "trap flag", int'(trap), int'(e_trap));
        check(int'(vl_out) == e_vl, tag, "vl_out", int'(vl_out), e_vl);
        check(int'(elem_offs) == e_oi, tag, "elem_offs", int'(elem_offs), e_oi);
        check(int'(sub_offs) == e_os, tag, "sub_offs", int'(sub_offs), e_os);
        @(negedge clk);
        check(done == 1'b0, "R13", "done one cycle", int'(done), 0);
        check(busy == 1'b0, "R13", "busy after end", int'(busy), 0);
    endtask

    task automatic setup(int vl, int sv, int ridx, int rsub, logic [31:0] m,
                         bit inv, bit x0, bit zr, bit ff);
        vl_in = 6'(vl); subvl_in = 3'(sv); res_idx = 5'(ridx); res_sub = 2'(rsub);
        mask = m; mask_inv = inv; pred_x0 = x0; zeroing = zr; ffirst = ff;
    endtask

    initial begin
        #2_000_000;
        check(1'b0, "R13", "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R13", "reset busy", int'(busy), 0);
        check(done == 1'b0, "R13", "reset done", int'(done), 0);
        check(issue_valid == 1'b0, "R13", "reset issue_valid", int'(issue_valid), 0);
        check(vl_out == 6'd0, "R13", "reset vl_out", int'(vl_out), 0);
        check(elem_offs == 5'd0, "R13", "reset elem_offs", int'(elem_offs), 0);

        // R1 R6: plain run, vector rd/rs1, scalar rs2
        rd_base = 7'd10; rs1_base = 7'd20; rs2_base = 7'd3;
        rd_vec = 1; rs1_vec = 1; rs2_vec = 0;
        setup(5, 1, 0, 0, 32'hFFFF_FFFF, 0, 0, 0, 0);
        run_case("R1_R6");

        // R7 R3 R1: sub-vector groups, skips, register wrap past 127
        stall_en = 1; rd_base = 7'd120; rs2_vec = 1;
        setup(4, 3, 0, 0, 32'b1010, 0, 0, 0, 0);
        run_case("R7_R3");

        // R4: zeroing writes for masked-out elements
        rd_base = 7'd8;
        setup(6, 1, 0, 0, 32'b101001, 0, 0, 1, 0);
        run_case("R4");

        // R10: zero-register source inverted gives all ones; inverted mask
        setup(3, 2, 0, 0, 32'h0, 1, 1, 0, 0);
        run_case("R10");
        setup(4, 1, 0, 0, 32'b0011, 1, 0, 0, 0);
        run_case("R10");

        // R5: exception freezes offsets, then R2 resumes there
        exc_i = 2; exc_s = 1;
        setup(4, 2, 0, 0, 32'hF, 0, 0, 0, 0);
        run_case("R5");
        exc_i = -1; exc_s = -1;
        setup(4, 2, int'(elem_offs), int'(sub_offs), 32'hF, 0, 0, 0, 0);
        run_case("R2");

        // R8 R9: fail-on-first on zero result, masked-out element 1 never fails
        zero_i = 3;
        setup(6, 1, 0, 0, 32'b111101, 0, 0, 0, 1);
        run_case("R8_R9");
        zero_i = -1;

        // R9: fail-on-first with zeroing ends on first masked-out element
        setup(6, 2, 0, 0, 32'b111011, 0, 0, 1, 1);
        run_case("R9");

        // R11: resume offsets beyond limits are clamped
        setup(4, 2, 9, 3, 32'hF, 0, 0, 0, 0);
        run_case("R11");

        // R12: long stalled run, in order
        setup(8, 4, 1, 2, 32'h5A, 0, 0, 1, 0);
        run_case("R12");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule